// File: doc/BRIEF.md
# Occupancy Counter with Step-Up, Step-Down and Add-Amount

This block keeps the occupancy count of a small queue. The count is one less than the number of held entries, and it is one bit wider than the queue's address field. An empty queue reads as all ones, which is minus one in two's complement. A count of zero therefore means one entry is held. The top bit doubles as an empty indicator, and the low bits address the entry that is read next.

Each cycle the surrounding logic can raise a step-up strobe, a step-down strobe and a multi-bit amount. The amount is used to put back entries that were already consumed. All three terms go into one adder. When step-down is raised, the amount is discarded for that cycle.

The block drives two outputs. One is the registered count. The other is a combinational look-ahead of the value the count takes at the next rising edge. The look-ahead lets neighbouring flag logic register its results in the same cycle as the count. Arithmetic wraps, and the block does no range checking of its own.

Top module: `occ_addn_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the count loads all ones, with every bit set.
- R2: Step-up alone, with the amount at zero, raises the count by one at the next edge.
- R3: Step-down alone lowers the count by one at the next edge.
- R4: Step-up and step-down together leave the count unchanged, whatever the amount is.
- R5: A nonzero amount without step-down raises the count by that amount. Together with step-up it raises the count by the amount plus one.
- R6: While step-down is high, the amount has no effect on the count.
- R7: `cnt_next_o` always equals the value `cnt_o` takes after the next rising edge outside reset. It depends only on the current count and the inputs.
- R8: The count wraps modulo 2^(ADDR_W+1) in both directions, with no clamping.
- R9: With ADDR_W=4, the top bit of the count is 1 when the queue is empty and 0 for occupancies 1 to 16.
- R10: With no strobe and a zero amount, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the empty code |
| inc_i | input | 1 | Step-up strobe, one entry added |
| dec_i | input | 1 | Step-down strobe, one entry taken |
| add_n_i | input | ADDR_W | Number of consumed entries to restore, zero-extended |
| cnt_o | output | ADDR_W+1 | Registered count, equal to occupancy minus one |
| cnt_next_o | output | ADDR_W+1 | Combinational value of the count after the next edge |

## Verification
A wrong count shows up on `cnt_o` one edge after the bad update. A wrong combining rule, such as an amount that is not cancelled or a dropped step-up, already shows on `cnt_next_o` in the same cycle, before any edge. Each cycle the bench compares both outputs against a model driven only by the strobes. A single corrupted bit is therefore reported within one clock. Runs that step across the all-ones code and the top-bit boundary expose carry and wrap faults that plain counting in the middle of the range would hide.

// File: rtl/occ_cnt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the occupancy counter.
// Assumes nothing beyond the strobe bundle definition.
package occ_cnt_pkg;

    // Step strobes bundled as they enter the adder.
    typedef struct packed {
        logic up;
        logic down;
    } occ_strobe_t;

endpackage

// File: rtl/occ_amount_gate.sv
`timescale 1ns/1ps
// Module: occ_amount_gate
// Zero-extends the restore amount to the count width and forces it to zero
// while step-down is active (step-down has priority over the amount).
// Assumes CNT_W = AMT_W + 1.
module occ_amount_gate #(
    parameter int AMT_W = 4,
    localparam int CNT_W = AMT_W + 1
) (
    input  logic             down_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [CNT_W-1:0] addend_o
);

    // Per-bit masking of the amount by the step-down strobe.
    for (genvar b = 0; b < AMT_W; b++) begin : g_mask
        assign addend_o[b] = amt_i[b] & ~down_i;
    end

    // Zero extension into the top bit.
    assign addend_o[CNT_W-1] = 1'b0;

endmodule

// File: rtl/occ_next_adder.sv
`timescale 1ns/1ps
// Module: occ_next_adder
// Single adder forming next = count + addend + up - down, modulo 2^CNT_W.
// Assumes the addend is already gated; purely combinational.
module occ_next_adder
    import occ_cnt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] addend_i,
    input  occ_strobe_t      strb_i,
    output logic [CNT_W-1:0] next_o
);

    logic [CNT_W-1:0] minus_one;
    logic [CNT_W-1:0] plus_one;

    // Step terms: minus one is all ones, plus one is a single carry-in.
    always_comb begin
        minus_one = {CNT_W{strb_i.down}};
        plus_one  = CNT_W'(strb_i.up);
    end

    // Wrapping sum of all terms.
    always_comb begin
        next_o = cnt_i + addend_i + plus_one + minus_one;
    end

endmodule

// File: rtl/occ_count_reg.sv
`timescale 1ns/1ps
// Module: occ_count_reg
// Holds the count; synchronous active-low reset loads all ones (empty).
// Assumes next_i is already the full next-state value.
module occ_count_reg #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Count register with empty-code reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '1;
        end else begin
            cnt_o <= next_i;
        end
    end

endmodule

// File: rtl/occ_addn_counter.sv
`timescale 1ns/1ps
// Module: occ_addn_counter (top)
// Occupancy-minus-one counter with step-up, step-down and a restore amount.
// Step-down cancels the amount in the same cycle. It exports the registered
// count and its combinational next value. No saturation: wraps modulo 2^CNT_W.
module occ_addn_counter
    import occ_cnt_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [ADDR_W-1:0] add_n_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cnt_next_o
);

    occ_strobe_t      strb;
    logic [CNT_W-1:0] addend;

    // Bundle the step strobes for the adder.
    always_comb begin
        strb.up   = inc_i;
        strb.down = dec_i;
    end

    occ_amount_gate #(.AMT_W(ADDR_W)) i_gate (
        .down_i   (dec_i),
        .amt_i    (add_n_i),
        .addend_o (addend)
    );

    occ_next_adder #(.CNT_W(CNT_W)) i_adder (
        .cnt_i    (cnt_o),
        .addend_i (addend),
        .strb_i   (strb),
        .next_o   (cnt_next_o)
    );

    occ_count_reg #(.CNT_W(CNT_W)) i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .next_i (cnt_next_o),
        .cnt_o  (cnt_o)
    );

endmodule

// File: rtl/occ_addn_counter_chk.sv
`timescale 1ns/1ps
// Module: occ_addn_counter_chk
// Property checker for occ_addn_counter, attached by bind below.
module occ_addn_counter_chk #(
    parameter int ADDR_W = 4,
    localparam int CNT_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc_i,
    input logic              dec_i,
    input logic [ADDR_W-1:0] add_n_i,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [CNT_W-1:0]  cnt_next_o
);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> cnt_o == {CNT_W{1'b1}});

    // R7
    lookahead_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt_o == $past(cnt_next_o));

    // R4
    up_down_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |-> cnt_next_o == cnt_o);

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |-> cnt_next_o == CNT_W'(cnt_o - CNT_W'(1)));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && add_n_i == '0) |-> cnt_next_o == CNT_W'(cnt_o + CNT_W'(1)));

    // R5
    amount_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && add_n_i != '0) |->
        cnt_next_o == CNT_W'(cnt_o + CNT_W'(add_n_i) + CNT_W'(inc_i)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !dec_i && add_n_i == '0) |=> $stable(cnt_o));

endmodule

bind occ_addn_counter occ_addn_counter_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (inc_i),
    .dec_i      (dec_i),
    .add_n_i    (add_n_i),
    .cnt_o      (cnt_o),
    .cnt_next_o (cnt_next_o)
);

// File: tb/test_occ_addn_counter.sv
`timescale 1ns/1ps
module test_occ_addn_counter;

    localparam int AW = 4;
    localparam int CW = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc = 1'b0;
    logic          dec = 1'b0;
    logic [AW-1:0] amt = '0;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [CW-1:0] exp_q[$];
    string         tag_q[$];
    logic [CW-1:0] model;

    always #10 clk = ~clk;

    occ_addn_counter #(.ADDR_W(AW)) i_occ_addn_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (inc),
        .dec_i      (dec),
        .add_n_i    (amt),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_nx)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, check look-ahead, queue expected count.
    task automatic drive(input logic i, input logic d, input logic [AW-1:0] n, input string req);
        logic [CW-1:0] nx;
        @(negedge clk);
        inc = i; dec = d; amt = n;
        nx = model + CW'(i) - CW'(d) + (d ? CW'(0) : CW'(n));
        #2;
        check("R7", cnt_nx, nx);
        exp_q.push_back(nx);
        tag_q.push_back(req);
        model = nx;
    endtask

    task automatic go_idle();
        @(negedge clk);
        inc = 1'b0; dec = 1'b0; amt = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; inc = 1'b0; dec = 1'b0; amt = '0;
        exp_q.push_back({CW{1'b1}});
        tag_q.push_back("R1");
        model = {CW{1'b1}};
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare the registered count against the scoreboard queue.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() != 0) begin
            logic [CW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, cnt, e);
        end
    end

    initial begin
        model = {CW{1'b1}};
        repeat (2) @(negedge clk);
        do_reset();
        #7;
        check("R9", {31'b0, cnt[CW-1]}, 32'd1);
        drive(0, 0, 0, "R10");
        drive(0, 0, 0, "R10");
        drive(1, 0, 0, "R2");                 // empty -> one entry (0)
        for (int k = 0; k < 15; k++) drive(1, 0, 0, "R9");
        go_idle();
        #7;
        check("R9", cnt, CW'(15));             // sixteen entries, top bit clear
        drive(1, 0, 0, "R8");                 // 16: carry into top bit
        drive(0, 1, 0, "R3");                 // 15
        drive(1, 1, 0, "R4");                 // 15
        drive(1, 1, 9, "R4");                 // 15, amount ignored
        drive(0, 1, 7, "R6");                 // 14, amount ignored
        drive(0, 0, 5, "R5");                 // 19
        drive(1, 0, 3, "R5");                 // 23
        drive(1, 0, 15, "R8");                // 39 mod 32 = 7
        go_idle();
        do_reset();
        drive(0, 1, 0, "R8");                 // 31 -> 30
        drive(1, 0, 0, "R2");                 // 31
        drive(1, 0, 0, "R8");                 // wraps to 0
        drive(0, 1, 0, "R8");                 // back to all ones
        for (int k = 0; k < 300; k++) begin
            drive(1'($urandom), 1'($urandom), AW'($urandom), "R8");
        end
        go_idle();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule